// File: doc/BRIEF.md
# Streaming QR Row-Update Engine with CORDIC Rotations

This block keeps the upper-triangular factor R of a complex data matrix with four columns. It never forms the orthogonal factor. Each time a producer presents a new data row, the engine folds it into R straight away, with no wait for a block of rows. Column by column, it first turns the leading element of the row into a real value. It then rotates that real value against the diagonal entry of R, which zeroes it, and applies the same rotation to the rest of the row pair. Every rotation is a run of CORDIC micro-steps built only from arithmetic shifts, additions and subtractions. The direction of each micro-step comes from a sign bit. No sine, cosine or quotient is ever formed.

A constant multiply removes the CORDIC gain after each rotation, and a register stage separates every micro-step. Once all columns are done, every entry of R is scaled by a forgetting factor of the form 1 - 2^-m. This is one shift and one subtract, so old rows fade and R stays bounded on an endless stream. A downstream solver reads R from the output buses when the done strobe pulses.

Top module: `cordicQrUpdater`

## Requirements
- R1: After reset, every entry of R reads zero, inReady is high and outValid is low.
- R2: A row is taken on a rising clock edge with inValid and inReady both high. inReady then stays low until the cycle after the outValid pulse.
- R3: outValid is high for exactly one cycle, 2*NCOL*(ITER+2)+1 clock edges after the accepting edge (113 with the defaults), and R on the outputs is final in that cycle.
- R4: Diagonal entries of R always have a zero imaginary part and a non-negative real part.
- R5: Folding a row into an all-zero R gives row 0 of R equal to the row times e^(-j*arg x0), then scaled by the forgetting factor, within 0.05. The other rows stay near zero.
- R6: After each update, R matches the exact complex Givens update within 0.05 per part. Entry (i,j) is at bit offset (i*NCOL+j)*W on rRe/rIm, in signed fixed point with FRAC fraction bits. The exact update makes each leading element real and non-negative, rotates it into the diagonal, and then multiplies all of R by 1 - 2^-FORGET_SHIFT. This holds for real, imaginary, negative-leading and mixed rows.
- R7: An all-zero row leaves R equal to its previous value times 1 - 2^-FORGET_SHIFT, within 0.05.
- R8: With row elements whose real and imaginary parts stay within ±1, the diagonal of R stays bounded on a long stream. R[0][0] stays below sqrt(2*NCOL/(1-λ^2)), about 8.13 with the defaults.
- R9: Entries of R below the diagonal are always exactly zero.
- R10: inValid and row data presented while inReady is low have no effect on R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Producer offers a row |
| inReady | output | 1 | Engine can take a row |
| inRe | input | NCOL*W | Real parts of the row, element j at bits j*W |
| inIm | input | NCOL*W | Imaginary parts of the row, element j at bits j*W |
| outValid | output | 1 | One-cycle strobe: update of R finished |
| rRe | output | NCOL*NCOL*W | Real parts of R, entry (i,j) at bits (i*NCOL+j)*W |
| rIm | output | NCOL*NCOL*W | Imaginary parts of R, same layout |

## Verification
The embedded checks assume that rows use at most a few units of range, so that R multiplied by the CORDIC gain of about 1.65 stays inside the signed W-bit word. They also assume that reset is applied before the first row. The bench keeps every row element within ±1, which bounds the diagonal near 8.1 against a limit of 128. It drives inValid only on falling edges, so the handshake assertions see clean one-cycle transfers. Rows offered while the engine is busy are deliberately junk values; they still stay inside the same range so that no overflow can hide a missed rejection.

// File: rtl/cordicQrPkg.sv
package cordicQrPkg;
  // strobes passed from the sequencer to the datapath
  typedef struct packed {
    logic       load;    // capture a new row
    logic       flip;    // pre-rotate by 180 degrees if the lead x is negative
    logic       iter;    // one CORDIC micro-step
    logic       gain;    // remove CORDIC gain
    logic       forget;  // apply forgetting factor to R
    logic       phaseB;  // 0: make row element real, 1: rotate against R
    logic [7:0] col;     // column being annihilated
    logic [7:0] shamt;   // micro-step shift amount
  } qrCtrlT;
endpackage

// File: rtl/cordicQrCtrl.sv
module cordicQrCtrl
  import cordicQrPkg::*;
#(
  parameter int NCOL = 4,
  parameter int ITER = 12
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  output logic   inReady,
  output logic   outValid,
  output qrCtrlT ctrl
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FORGET, S_DONE} stateT;
  localparam int LastStep = ITER + 1;

  stateT      stateQ;
  logic [7:0] colQ;
  logic [7:0] stepQ;
  logic       phaseBQ;

  assign inReady  = (stateQ == S_IDLE);
  assign outValid = (stateQ == S_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      colQ    <= '0;
      stepQ   <= '0;
      phaseBQ <= 1'b0;
    end else begin
      case (stateQ)
        S_IDLE: if (inValid) begin
          stateQ  <= S_RUN;
          colQ    <= '0;
          stepQ   <= '0;
          phaseBQ <= 1'b0;
        end
        S_RUN: begin
          if (int'(stepQ) == LastStep) begin
            stepQ <= '0;
            if (phaseBQ) begin
              phaseBQ <= 1'b0;
              if (int'(colQ) == NCOL - 1) stateQ <= S_FORGET;
              else colQ <= colQ + 8'd1;
            end else begin
              phaseBQ <= 1'b1;
            end
          end else begin
            stepQ <= stepQ + 8'd1;
          end
        end
        S_FORGET: stateQ <= S_DONE;
        default:  stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl        = '0;
    ctrl.load   = (stateQ == S_IDLE) && inValid;
    ctrl.col    = colQ;
    ctrl.phaseB = phaseBQ;
    ctrl.shamt  = stepQ - 8'd1;
    ctrl.forget = (stateQ == S_FORGET);
    if (stateQ == S_RUN) begin
      ctrl.flip = (stepQ == 8'd0);
      ctrl.iter = (stepQ != 8'd0) && (int'(stepQ) <= ITER);
      ctrl.gain = (int'(stepQ) == LastStep);
    end
  end

  // R3: done strobe lasts one cycle and hands control back to the producer
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  a_r3_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> inReady);
  // R2: an accepted row closes the gate on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);
  a_r2_ready_reopens_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> $past(outValid));
endmodule

// File: rtl/cordicQrDatapath.sv
module cordicQrDatapath
  import cordicQrPkg::*;
#(
  parameter int NCOL         = 4,
  parameter int W            = 20,
  parameter int FRAC         = 12,
  parameter int FORGET_SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  qrCtrlT                 ctrl,
  input  logic [NCOL*W-1:0]      inRe,
  input  logic [NCOL*W-1:0]      inIm,
  output logic [NCOL*NCOL*W-1:0] rReFlat,
  output logic [NCOL*NCOL*W-1:0] rImFlat
);
  localparam int IdxW    = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int GW      = FRAC + 2;
  localparam int PW      = W + GW;
  localparam int InvGInt = int'(0.6072529350 * real'(1 << FRAC));
  localparam logic signed [GW-1:0] InvGain = InvGInt[GW-1:0];

  logic signed [W-1:0] rRe [NCOL][NCOL];
  logic signed [W-1:0] rIm [NCOL][NCOL];
  logic signed [W-1:0] xRe [NCOL];
  logic signed [W-1:0] xIm [NCOL];

  logic [IdxW-1:0]     c;
  logic signed [W-1:0] leadX, leadY;
  logic                neg, flipNeed;

  assign c        = ctrl.col[IdxW-1:0];
  assign leadX    = ctrl.phaseB ? rRe[c][c] : xRe[c];
  assign leadY    = ctrl.phaseB ? xRe[c]    : xIm[c];
  assign neg      = leadY[W-1];
  assign flipNeed = leadX[W-1];

  function automatic logic signed [W-1:0] rotA(logic signed [W-1:0] a, logic signed [W-1:0] b,
                                               logic n, logic [7:0] sh);
    return n ? a - (b >>> sh) : a + (b >>> sh);
  endfunction

  function automatic logic signed [W-1:0] rotB(logic signed [W-1:0] a, logic signed [W-1:0] b,
                                               logic n, logic [7:0] sh);
    return n ? b + (a >>> sh) : b - (a >>> sh);
  endfunction

  function automatic logic signed [W-1:0] gmul(logic signed [W-1:0] v);
    logic signed [PW-1:0] p;
    p = $signed({{GW{v[W-1]}}, v}) * $signed({{W{InvGain[GW-1]}}, InvGain});
    return p[FRAC+W-1:FRAC];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCOL; i++) begin
        xRe[i] <= '0;
        xIm[i] <= '0;
        for (int j = 0; j < NCOL; j++) begin
          rRe[i][j] <= '0;
          rIm[i][j] <= '0;
        end
      end
    end else if (ctrl.load) begin
      for (int j = 0; j < NCOL; j++) begin
        xRe[j] <= inRe[j*W +: W];
        xIm[j] <= inIm[j*W +: W];
      end
    end else if (ctrl.forget) begin
      for (int i = 0; i < NCOL; i++)
        for (int j = 0; j < NCOL; j++) begin
          rRe[i][j] <= rRe[i][j] - (rRe[i][j] >>> FORGET_SHIFT);
          rIm[i][j] <= rIm[i][j] - (rIm[i][j] >>> FORGET_SHIFT);
        end
    end else if (!ctrl.phaseB) begin
      // phase A: rotate row elements so the lead one becomes real
      for (int j = 0; j < NCOL; j++) begin
        if (j >= int'(c)) begin
          if (ctrl.flip && flipNeed) begin
            xRe[j] <= -xRe[j];
            xIm[j] <= -xIm[j];
          end else if (ctrl.iter) begin
            xRe[j] <= rotA(xRe[j], xIm[j], neg, ctrl.shamt);
            xIm[j] <= rotB(xRe[j], xIm[j], neg, ctrl.shamt);
          end else if (ctrl.gain) begin
            xRe[j] <= gmul(xRe[j]);
            xIm[j] <= (j == int'(c)) ? '0 : gmul(xIm[j]);
          end
        end
      end
    end else begin
      // phase B: real Givens rotation of R row c against the data row
      for (int i = 0; i < NCOL; i++) begin
        if (i == int'(c)) begin
          for (int j = 0; j < NCOL; j++) begin
            if (j >= i) begin
              if (ctrl.flip && flipNeed) begin
                rRe[i][j] <= -rRe[i][j];
                rIm[i][j] <= -rIm[i][j];
                xRe[j]    <= -xRe[j];
                xIm[j]    <= -xIm[j];
              end else if (ctrl.iter) begin
                rRe[i][j] <= rotA(rRe[i][j], xRe[j], neg, ctrl.shamt);
                xRe[j]    <= rotB(rRe[i][j], xRe[j], neg, ctrl.shamt);
                rIm[i][j] <= rotA(rIm[i][j], xIm[j], neg, ctrl.shamt);
                xIm[j]    <= rotB(rIm[i][j], xIm[j], neg, ctrl.shamt);
              end else if (ctrl.gain) begin
                rRe[i][j] <= gmul(rRe[i][j]);
                rIm[i][j] <= gmul(rIm[i][j]);
                xRe[j]    <= gmul(xRe[j]);
                xIm[j]    <= gmul(xIm[j]);
              end
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCOL; i++)
      for (int j = 0; j < NCOL; j++) begin
        rReFlat[(i*NCOL+j)*W +: W] = rRe[i][j];
        rImFlat[(i*NCOL+j)*W +: W] = rIm[i][j];
      end
  end

  for (genvar k = 0; k < NCOL; k++) begin : gDiagChk
    // R4: diagonal stays real and non-negative through every micro-step
    a_r4_diag_real: assert property (@(posedge clk) disable iff (!rstN)
      (rIm[k][k] == '0) && !rRe[k][k][W-1]);
    for (genvar m = 0; m < k; m++) begin : gLowChk
      // R9: nothing below the diagonal is ever written
      a_r9_lower_zero: assert property (@(posedge clk) disable iff (!rstN)
        (rRe[k][m] == '0) && (rIm[k][m] == '0));
    end
  end
endmodule

// File: rtl/cordicQrUpdater.sv
module cordicQrUpdater
  import cordicQrPkg::*;
#(
  parameter int NCOL         = 4,
  parameter int W            = 20,
  parameter int FRAC         = 12,
  parameter int FORGET_SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [NCOL*W-1:0]      inRe,
  input  logic [NCOL*W-1:0]      inIm,
  output logic                   outValid,
  output logic [NCOL*NCOL*W-1:0] rRe,
  output logic [NCOL*NCOL*W-1:0] rIm
);
  localparam int ITER = FRAC;

  qrCtrlT ctrl;

  cordicQrCtrl #(.NCOL(NCOL), .ITER(ITER)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .ctrl(ctrl)
  );

  cordicQrDatapath #(.NCOL(NCOL), .W(W), .FRAC(FRAC), .FORGET_SHIFT(FORGET_SHIFT)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inRe(inRe), .inIm(inIm),
    .rReFlat(rRe), .rImFlat(rIm)
  );
endmodule

// File: tb/cordicQrUpdater_tb_top.sv
`timescale 1ns/1ps
module cordicQrUpdater_tb_top;
  localparam int  NCOL    = 4;
  localparam int  W       = 20;
  localparam int  FRAC    = 12;
  localparam int  FSH     = 4;
  localparam int  LATENCY = 2*NCOL*(FRAC+2)+1;
  localparam real SCALE   = 4096.0;
  localparam real LAMBDA  = 1.0 - 1.0/16.0;
  localparam real TOL     = 0.05;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady, outValid;
  logic [NCOL*W-1:0]      inRe = '0, inIm = '0;
  logic [NCOL*NCOL*W-1:0] rRe, rIm;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;
  real mRe [NCOL][NCOL];
  real mIm [NCOL][NCOL];
  real rowRe [NCOL];
  real rowIm [NCOL];

  always #2.5 clk = ~clk;

  cordicQrUpdater #(.NCOL(NCOL), .W(W), .FRAC(FRAC), .FORGET_SHIFT(FSH)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inRe(inRe), .inIm(inIm), .outValid(outValid), .rRe(rRe), .rIm(rIm)
  );

  function automatic real outVal(logic [NCOL*NCOL*W-1:0] bus, int i, int j);
    logic signed [W-1:0] v;
    v = bus[(i*NCOL+j)*W +: W];
    return real'(v) / SCALE;
  endfunction

  function automatic real absr(real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic check(bit ok, string req, string what, real act, real exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
    end
  endtask

  // exact floating-point reference update
  task automatic modelUpdate();
    real xr [NCOL];
    real xi [NCOL];
    for (int j = 0; j < NCOL; j++) begin
      xr[j] = rowRe[j];
      xi[j] = rowIm[j];
    end
    for (int k = 0; k < NCOL; k++) begin
      real mag, cs, sn, rr, a, b, ar, ai;
      mag = $sqrt(xr[k]*xr[k] + xi[k]*xi[k]);
      if (mag > 0.0) begin
        cs = xr[k] / mag;
        sn = xi[k] / mag;
        for (int j = k; j < NCOL; j++) begin
          a = xr[j]; b = xi[j];
          xr[j] = a*cs + b*sn;
          xi[j] = b*cs - a*sn;
        end
        xi[k] = 0.0;
      end
      rr = $sqrt(mRe[k][k]*mRe[k][k] + xr[k]*xr[k]);
      if (rr > 0.0) begin
        cs = mRe[k][k] / rr;
        sn = xr[k] / rr;
        for (int j = k; j < NCOL; j++) begin
          ar = mRe[k][j]; ai = mIm[k][j];
          mRe[k][j] = cs*ar + sn*xr[j];
          mIm[k][j] = cs*ai + sn*xi[j];
          xr[j] = -sn*ar + cs*xr[j];
          xi[j] = -sn*ai + cs*xi[j];
        end
      end
    end
    for (int i = 0; i < NCOL; i++)
      for (int j = 0; j < NCOL; j++) begin
        mRe[i][j] = mRe[i][j] * LAMBDA;
        mIm[i][j] = mIm[i][j] * LAMBDA;
      end
  endtask

  task automatic compareR(string req);
    for (int i = 0; i < NCOL; i++)
      for (int j = 0; j < NCOL; j++) begin
        check(absr(outVal(rRe, i, j) - mRe[i][j]) <= TOL, req, $sformatf("re(%0d,%0d)", i, j),
              outVal(rRe, i, j), mRe[i][j]);
        check(absr(outVal(rIm, i, j) - mIm[i][j]) <= TOL, req, $sformatf("im(%0d,%0d)", i, j),
              outVal(rIm, i, j), mIm[i][j]);
        if (i == j) begin
          check(outVal(rIm, i, i) == 0.0 && outVal(rRe, i, i) >= 0.0, "R4", "diag real",
                outVal(rIm, i, i), 0.0);
        end
        if (i > j) begin
          check(outVal(rRe, i, j) == 0.0 && outVal(rIm, i, j) == 0.0, "R9", "lower zero",
                outVal(rRe, i, j), 0.0);
        end
      end
  endtask

  // drive rowRe/rowIm, wait for completion, check handshake and latency
  task automatic sendRow(bit junkWhileBusy);
    int  cyc;
    bit  readyLeak;
    real q;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    for (int j = 0; j < NCOL; j++) begin
      q = rowRe[j] * SCALE; inRe[j*W +: W] = W'($rtoi(q));
      rowRe[j] = real'($rtoi(q)) / SCALE;
      q = rowIm[j] * SCALE; inIm[j*W +: W] = W'($rtoi(q));
      rowIm[j] = real'($rtoi(q)) / SCALE;
    end
    inValid = 1'b1;
    @(negedge clk);
    cyc = 0;
    readyLeak = inReady;
    if (junkWhileBusy) begin
      inRe = {NCOL{20'sh00C00}};
      inIm = {NCOL{20'shFF400}};
    end else begin
      inValid = 1'b0;
    end
    while (!outValid && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (!outValid && inReady) readyLeak = 1'b1;
    end
    inValid = 1'b0;
    check(!readyLeak, "R2", "inReady low while busy", real'(readyLeak), 0.0);
    check(cyc == LATENCY, "R3", "done latency", real'(cyc), real'(LATENCY));
    @(negedge clk);
    check(!outValid, "R3", "single pulse", real'(outValid), 0.0);
    check(inReady, "R2", "ready after done", real'(inReady), 1.0);
    modelUpdate();
  endtask

  task automatic testReset();
    bit allZero = (rRe == '0) && (rIm == '0);
    check(allZero, "R1", "R zero after reset", real'(!allZero), 0.0);
    check(inReady, "R1", "ready after reset", real'(inReady), 1.0);
    check(!outValid, "R1", "no done after reset", real'(outValid), 0.0);
  endtask

  task automatic testFirstRow();
    rowRe = '{0.5, -0.25, 0.75, 0.1};
    rowIm = '{0.5, 0.3, -0.2, -0.6};
    sendRow(0);
    compareR("R5");
  endtask

  task automatic testPatterns();
    rowRe = '{-0.8, 0.2, 0.4, -0.3};  rowIm = '{0.1, -0.5, 0.6, 0.2};  sendRow(0); compareR("R6");
    rowRe = '{0.0, 0.0, 0.0, 0.0};    rowIm = '{0.9, -0.7, 0.3, 0.5};  sendRow(0); compareR("R6");
    rowRe = '{0.6, -0.9, 0.2, 0.7};   rowIm = '{0.0, 0.0, 0.0, 0.0};   sendRow(0); compareR("R6");
    rowRe = '{-0.1, 0.8, -0.6, 0.35}; rowIm = '{-0.9, 0.05, 0.4, -0.7}; sendRow(0); compareR("R6");
  endtask

  task automatic testZeroRow();
    rowRe = '{0.0, 0.0, 0.0, 0.0};
    rowIm = '{0.0, 0.0, 0.0, 0.0};
    sendRow(0);
    compareR("R7");
  endtask

  task automatic testBusyIgnored();
    rowRe = '{0.3, 0.4, -0.5, 0.2};
    rowIm = '{-0.2, 0.6, 0.1, -0.4};
    sendRow(1);
    compareR("R10");
  endtask

  task automatic testBound();
    for (int n = 0; n < 40; n++) begin
      real sgn = (n % 2 == 0) ? 1.0 : -1.0;
      rowRe = '{0.99, -0.99*sgn, 0.99, 0.99*sgn};
      rowIm = '{0.99*sgn, 0.99, -0.99, 0.99*sgn};
      sendRow(0);
    end
    check(outVal(rRe, 0, 0) < 8.13 + TOL, "R8", "diag bound", outVal(rRe, 0, 0), 8.13);
    compareR("R8");
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCOL; i++)
      for (int j = 0; j < NCOL; j++) begin
        mRe[i][j] = 0.0;
        mIm[i][j] = 0.0;
      end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstRow();
    testPatterns();
    testZeroRow();
    testBusyIgnored();
    testBound();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule